// File: doc/BRIEF.md
# Fuse Burn Sequencer

This block is the master that drives a one-time-programmable fuse controller through one complete burn. The fuse array holds 64 words organised as 32 pairs; every pair is a primary word (even address) and its shadow (odd address), and the two are always burned with the same value. The caller presents a 32-word image and a 32-word mask, states what kind of request it is, and pulses `start`. The sequencer then steps the controller through the whole burn:

- arm the write-protect bits;
- re-sense and work out which bits are both requested and still unburned;
- burn the pairs from the top down;
- cycle power around the control words held in pairs 1 and 0;
- trigger the reload of the sensed values and poll for its completion.

The block issues commands on a simple held-until-acknowledged port (`cmd_op`: 1 = read, 2 = write, 3 = sense). It owns the program-power enable and the write-access enable. It reports the outcome as a one-cycle `done`, `timeout` or `rejected` pulse. The image, mask and request-kind inputs must be held stable while `busy` is high.

Top module: `fuse_burn_seq`

## Requirements
- R1: A start with both `req_prod` and `req_key` high is refused. `rejected` pulses in the cycle after the start, and no command is issued.
- R2: Every accepted start opens with sense, read of address 0 and read of address 1, all with power off. If bit 4 (the production-lock bit) of word 0 is set and `req_rsvd_only` is low, the run stops with `rejected` and issues no further command. `locked` then shows that bit.
- R3: After a power-on settle, the sequencer writes address 0 and then address 1. Each write carries only bit 0 (the write-protect bit), and only where the word read in R2 has that bit clear.
- R4: After power-off and a sense, the sequencer reads the even addresses 0, 2, … 62 in ascending order. For pair i it keeps burn[i] = image[i] AND NOT read(2i) AND mask[i].
- R5: Pairs are handled from index 31 down to 0. A nonzero burn[i] is written to address 2i and then to 2i+1. A zero burn[i] issues no command.
- R6: Immediately after pair 1 and after pair 0, power goes off, a sense is issued and power comes back on.
- R7: No command is issued within SETTLE_CYC cycles of a change of `pwr_good`. Writes occur only with power and write access on. Reads and senses occur only with power off.
- R8: After the last pair, power and write access turn off and a sense is issued. `reload_go` then pulses once. `load_done` and `ctl_idle` are sampled every POLL_CYC cycles, and `done` follows the first sample that finds both high.
- R9: If MAX_POLLS samples all fail, `timeout` pulses in the cycle after the last sample.
- R10: `start` is ignored while `busy`. `done`, `timeout` and `rejected` are single-cycle pulses, never more than one at a time.
- R11: A command holds `cmd_valid`, `cmd_op`, `cmd_addr` and `cmd_wdata` steady until the cycle `cmd_done` is high.
- R12: After reset the block is idle, with no command, power off, write access closed and all outcome outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burn run |
| req_rsvd_only | input | 1 | Request touches only the reserved region |
| req_prod | input | 1 | Request sets the production-lock field |
| req_key | input | 1 | Request sets a key field |
| img_data | input | PAIRS*DW | Requested value per pair, pair i at bits i*DW |
| img_mask | input | PAIRS*DW | Bits of each pair allowed to burn |
| cmd_valid | output | 1 | Command request to the controller |
| cmd_op | output | 2 | 1 read, 2 write, 3 sense |
| cmd_addr | output | AW | Fuse word address |
| cmd_wdata | output | DW | Write value |
| cmd_done | input | 1 | Command completed this cycle |
| cmd_rdata | input | DW | Read value, valid with cmd_done |
| pwr_good | output | 1 | Program-power enable |
| wr_open | output | 1 | Write access enable |
| reload_go | output | 1 | One-cycle start/skip-repair reload trigger |
| ctl_idle | input | 1 | Controller idle status |
| load_done | input | 1 | Sense-and-shift completion status |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, reload confirmed |
| timeout | output | 1 | Reload poll gave up |
| rejected | output | 1 | Request refused |
| locked | output | 1 | Production-lock bit seen at last opening read |

## Verification
The bench builds the full expected command stream from its own fuse-array model and matches every acknowledged command, together with the power state at that moment. A sequencer that burned already-blown bits, skipped the shadow word, walked pairs upward or wrote zero pairs would therefore diverge on a specific command. Pairs whose mask is zero and a repeat run that finds nothing left to burn test the skip rule. The power cycle after pairs 1 and 0 is checked, as is the settle gap after each power change, which catches a sequencer that commands during settling. The production-lock and production-plus-key refusals are checked at the command port and by the cycle of `rejected`. The reload poll is timed to the exact cycle in both its success and its give-up forms, so a wrong poll period or an off-by-one poll count shows. A second start sent mid-run would add commands if it were not ignored.

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq #(
  parameter int PAIRS      = 32,
  parameter int DW         = 32,
  parameter int SETTLE_CYC = 8,
  parameter int POLL_CYC   = 1000,
  parameter int MAX_POLLS  = 50,
  parameter int WP_BIT     = 0,
  parameter int LOCK_BIT   = 4,
  localparam int PIW  = $clog2(PAIRS),
  localparam int AW   = PIW + 1,
  localparam int CMAX = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC,
  localparam int CW   = $clog2(CMAX + 1),
  localparam int PLW  = $clog2(MAX_POLLS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                req_rsvd_only,
  input  logic                req_prod,
  input  logic                req_key,
  input  logic [PAIRS*DW-1:0] img_data,
  input  logic [PAIRS*DW-1:0] img_mask,
  output logic                cmd_valid,
  output logic [1:0]          cmd_op,
  output logic [AW-1:0]       cmd_addr,
  output logic [DW-1:0]       cmd_wdata,
  input  logic                cmd_done,
  input  logic [DW-1:0]       cmd_rdata,
  output logic                pwr_good,
  output logic                wr_open,
  output logic                reload_go,
  input  logic                ctl_idle,
  input  logic                load_done,
  output logic                busy,
  output logic                done,
  output logic                timeout,
  output logic                rejected,
  output logic                locked
);
  localparam logic [1:0] OP_RD = 2'd1, OP_WR = 2'd2, OP_SNS = 2'd3;
  localparam logic [DW-1:0] WP_MASK = DW'(1) << WP_BIT;

  typedef enum logic [4:0] {
    IDLE, SNS0, RD0, RD1, WP0, WP1, SNS1, SCAN, NEXT, BURN0, BURN1,
    POST, CSNS, STEP, FSNS, RELOAD, POLL, SETTLE
  } st_t;

  st_t            st, ret;
  logic [CW-1:0]  cnt;
  logic [PLW-1:0] polls;
  logic [PIW-1:0] idx;
  logic [DW-1:0]  w0, w1;
  logic [DW-1:0]  burn [PAIRS];
  logic           pwr, wopen, lock_q, rsvd_q, done_q, to_q, rej_q;

  assign busy      = (st != IDLE);
  assign pwr_good  = pwr;
  assign wr_open   = wopen;
  assign reload_go = (st == RELOAD);
  assign done      = done_q;
  assign timeout   = to_q;
  assign rejected  = rej_q;
  assign locked    = lock_q;

  always_comb begin
    cmd_valid = 1'b1;
    cmd_op    = OP_SNS;
    cmd_addr  = '0;
    cmd_wdata = '0;
    case (st)
      SNS0, SNS1, CSNS, FSNS: cmd_op = OP_SNS;
      RD0:   cmd_op = OP_RD;
      RD1:   begin cmd_op = OP_RD; cmd_addr = AW'(1); end
      WP0:   begin cmd_op = OP_WR; cmd_wdata = ~w0 & WP_MASK; end
      WP1:   begin cmd_op = OP_WR; cmd_addr = AW'(1); cmd_wdata = ~w1 & WP_MASK; end
      SCAN:  begin cmd_op = OP_RD; cmd_addr = {idx, 1'b0}; end
      BURN0: begin cmd_op = OP_WR; cmd_addr = {idx, 1'b0}; cmd_wdata = burn[idx]; end
      BURN1: begin cmd_op = OP_WR; cmd_addr = {idx, 1'b1}; cmd_wdata = burn[idx]; end
      default: cmd_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk)
    if (st == SCAN && cmd_done)
      burn[idx] <= img_data[idx*DW +: DW] & ~cmd_rdata & img_mask[idx*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ret <= IDLE; cnt <= '0; polls <= '0; idx <= '0;
      w0 <= '0; w1 <= '0; pwr <= 1'b0; wopen <= 1'b0; lock_q <= 1'b0;
      rsvd_q <= 1'b0; done_q <= 1'b0; to_q <= 1'b0; rej_q <= 1'b0;
    end else begin
      done_q <= 1'b0; to_q <= 1'b0; rej_q <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (req_prod && req_key) rej_q <= 1'b1;
          else begin rsvd_q <= req_rsvd_only; st <= SNS0; end
        end
        SNS0: if (cmd_done) st <= RD0;
        RD0: if (cmd_done) begin
          w0 <= cmd_rdata; lock_q <= cmd_rdata[LOCK_BIT]; st <= RD1;
        end
        RD1: if (cmd_done) begin
          w1 <= cmd_rdata;
          if (w0[LOCK_BIT] && !rsvd_q) begin rej_q <= 1'b1; st <= IDLE; end
          else begin wopen <= 1'b1; pwr <= 1'b1; cnt <= '0; ret <= WP0; st <= SETTLE; end
        end
        WP0: if (cmd_done) st <= WP1;
        WP1: if (cmd_done) begin pwr <= 1'b0; cnt <= '0; ret <= SNS1; st <= SETTLE; end
        SNS1: if (cmd_done) begin idx <= '0; st <= SCAN; end
        SCAN: if (cmd_done) begin
          if (idx == PIW'(PAIRS-1)) begin pwr <= 1'b1; cnt <= '0; ret <= NEXT; st <= SETTLE; end
          else idx <= idx + 1'b1;
        end
        NEXT:  st <= (|burn[idx]) ? BURN0 : POST;
        BURN0: if (cmd_done) st <= BURN1;
        BURN1: if (cmd_done) st <= POST;
        POST: if (idx <= PIW'(1)) begin pwr <= 1'b0; cnt <= '0; ret <= CSNS; st <= SETTLE; end
              else begin idx <= idx - 1'b1; st <= NEXT; end
        CSNS: if (cmd_done) begin pwr <= 1'b1; cnt <= '0; ret <= STEP; st <= SETTLE; end
        STEP: if (idx == '0) begin
                pwr <= 1'b0; wopen <= 1'b0; cnt <= '0; ret <= FSNS; st <= SETTLE;
              end else begin idx <= idx - 1'b1; st <= NEXT; end
        FSNS: if (cmd_done) st <= RELOAD;
        RELOAD: begin cnt <= '0; polls <= '0; st <= POLL; end
        POLL: if (cnt == CW'(POLL_CYC-1)) begin
          cnt <= '0;
          if (load_done && ctl_idle) begin done_q <= 1'b1; st <= IDLE; end
          else if (polls == PLW'(MAX_POLLS-1)) begin to_q <= 1'b1; st <= IDLE; end
          else polls <= polls + 1'b1;
        end else cnt <= cnt + 1'b1;
        SETTLE: if (cnt == CW'(SETTLE_CYC-1)) st <= ret;
                else cnt <= cnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fuse_burn_seq_chk.sv
module fuse_burn_seq_chk #(
  parameter int SETTLE_CYC = 8,
  parameter int AW = 6,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [AW-1:0] cmd_addr,
  input logic [DW-1:0] cmd_wdata,
  input logic          cmd_done,
  input logic          pwr_good,
  input logic          wr_open,
  input logic          reload_go,
  input logic          busy,
  input logic          done,
  input logic          timeout,
  input logic          rejected
);
  logic prev_pwr;
  int   age_q, age_now;

  assign age_now = (pwr_good != prev_pwr) ? 0 : age_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin prev_pwr <= 1'b0; age_q <= SETTLE_CYC; end
    else begin
      prev_pwr <= pwr_good;
      age_q    <= (age_now >= SETTLE_CYC) ? SETTLE_CYC : age_now + 1;
    end

  always @(posedge clk)
    if (rst_n && cmd_valid)
      AST_SETTLE_GAP: assert (age_now >= SETTLE_CYC); // R7

  AST_WRITE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd2 |-> pwr_good && wr_open); // R7
  AST_READ_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op != 2'd2 |-> !pwr_good); // R7
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_wdata)); // R11
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timeout, rejected})); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !pwr_good && !wr_open); // R12
  AST_RELOAD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    reload_go |-> !wr_open && !pwr_good); // R8
endmodule

bind fuse_burn_seq fuse_burn_seq_chk #(.SETTLE_CYC(SETTLE_CYC), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_fuse_burn_seq.sv
module tb_fuse_burn_seq;
  localparam int CLK_P = 10;
  localparam int PAIRS = 32, SET = 4, POLL = 20, MAXP = 50;

  logic clk = 0, rst_n = 0, start = 0, rsvd = 0, rq_prod = 0, rq_key = 0;
  logic [PAIRS*32-1:0] img = '0, msk = '0;
  logic cmd_done = 0, ctl_idle = 1, load_done = 0;
  logic [31:0] rdata = '0;
  wire cmd_valid, pwr_good, wr_open, reload_go, busy, done, timeout, rejected, locked;
  wire [1:0] cmd_op;
  wire [5:0] cmd_addr;
  wire [31:0] cmd_wdata;

  fuse_burn_seq #(.PAIRS(PAIRS), .DW(32), .SETTLE_CYC(SET), .POLL_CYC(POLL), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_rsvd_only(rsvd), .req_prod(rq_prod),
    .req_key(rq_key), .img_data(img), .img_mask(msk), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_rdata(rdata),
    .pwr_good(pwr_good), .wr_open(wr_open), .reload_go(reload_go), .ctl_idle(ctl_idle),
    .load_done(load_done), .busy(busy), .done(done), .timeout(timeout), .rejected(rejected),
    .locked(locked));

  always #(CLK_P/2) clk = ~clk;

  logic [31:0] fa [64];
  logic [31:0] ef [64];
  logic [40:0] exq [$];
  string       tq [$];
  logic [40:0] e, act;
  string       etag;
  int tests = 0, fails = 0, cyc = 0, lat = 0, age = 1000;
  int reload_cyc = -1, out_cyc = -1, st_cyc = -1;
  int n_done = 0, n_to = 0, n_rej = 0, r7_bad = 0, pulse_bad = 0;
  bit arm = 0;
  logic pprev = 0, pd = 0, pt = 0, pr = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] a, input logic [63:0] x);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, a, x);
    end
  endtask

  function automatic logic [40:0] pk(input logic p, input logic [1:0] op, input int a, input logic [31:0] d);
    return {p, op, 6'(a), d};
  endfunction

  task automatic push(input logic p, input logic [1:0] op, input int a, input logic [31:0] d, input string t);
    exq.push_back(pk(p, op, a, d));
    tq.push_back(t);
  endtask

  // reference command stream from the fuse-array model
  task automatic build(input bit lockrej);
    logic [31:0] b [PAIRS];
    exq.delete(); tq.delete();
    for (int k = 0; k < 64; k++) ef[k] = fa[k];
    push(0, 3, 0, 0, "R2"); push(0, 1, 0, 0, "R2"); push(0, 1, 1, 0, "R2");
    if (lockrej) return;
    push(1, 2, 0, ~ef[0] & 32'h1, "R3"); push(1, 2, 1, ~ef[1] & 32'h1, "R3");
    ef[0] |= 32'h1; ef[1] |= 32'h1;
    push(0, 3, 0, 0, "R4");
    for (int i = 0; i < PAIRS; i++) begin
      push(0, 1, 2*i, 0, "R4");
      b[i] = img[i*32 +: 32] & ~ef[2*i] & msk[i*32 +: 32];
    end
    for (int i = PAIRS-1; i >= 0; i--) begin
      if (b[i] != 0) begin
        push(1, 2, 2*i, b[i], "R5"); push(1, 2, 2*i+1, b[i], "R5");
        ef[2*i] |= b[i]; ef[2*i+1] |= b[i];
      end
      if (i < 2) push(0, 3, 0, 0, "R6");
    end
    push(0, 3, 0, 0, "R8");
  endtask

  always @(negedge clk) begin
    cyc++;
    if (pwr_good !== pprev) age = 0; else age++;
    pprev = pwr_good;
    if (cmd_valid && age < SET) r7_bad++;
    if ((done && pd) || (timeout && pt) || (rejected && pr)) pulse_bad++;
    pd = done; pt = timeout; pr = rejected;
    if (start) st_cyc = cyc;
    if (done)     begin n_done++; out_cyc = cyc; end
    if (timeout)  begin n_to++;   out_cyc = cyc; end
    if (rejected) begin n_rej++;  out_cyc = cyc; end
    if (reload_go) begin
      reload_cyc = cyc;
      chk(!wr_open && !pwr_good, "R8", {wr_open, pwr_good}, 0);
    end
    if (arm && reload_cyc >= 0 && cyc == reload_cyc + 2*POLL + 5) load_done = 1;
    if (cmd_done) cmd_done = 0;
    else if (rst_n && cmd_valid) begin
      lat++;
      if (lat >= 2) begin
        lat = 0;
        cmd_done = 1;
        rdata = fa[cmd_addr];
        act = {pwr_good, cmd_op, cmd_addr, (cmd_op == 2'd2) ? cmd_wdata : 32'h0};
        if (cmd_op == 2'd2) begin
          if (!wr_open) chk(0, "R7", 0, 1);
          fa[cmd_addr] |= cmd_wdata;
        end
        if (exq.size() == 0) chk(0, "R10 unexpected command", 64'(act), 0);
        else begin
          e = exq.pop_front(); etag = tq.pop_front();
          chk(act == e, etag, 64'(act), 64'(e));
        end
      end
    end else lat = 0;
  end

  // outcome: 0 done, 1 timeout, 2 rejected
  task automatic run(input int outcome, input bit poke);
    int n0;
    n0 = n_done + n_to + n_rej;
    load_done = 0; arm = (outcome == 0); reload_cyc = -1;
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    if (poke) begin
      repeat (30) @(posedge clk);
      #1 start = 1;
      @(posedge clk); #1 start = 0;
    end
    while (n_done + n_to + n_rej == n0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_done + n_to + n_rej == n0 + 1, "R10 single outcome", n_done + n_to + n_rej - n0, 1);
    chk(exq.size() == 0, "R5 stream complete", exq.size(), 0);
    if (outcome == 0) chk(out_cyc - reload_cyc == 3*POLL + 1, "R8 poll timing", out_cyc - reload_cyc, 3*POLL + 1);
    if (outcome == 1) chk(out_cyc - reload_cyc == MAXP*POLL + 1, "R9 timeout timing", out_cyc - reload_cyc, MAXP*POLL + 1);
    arm = 0;
  endtask

  task automatic cmp_array(input string rq);
    int bad = 0;
    for (int k = 0; k < 64; k++) if (fa[k] !== ef[k]) bad++;
    chk(bad == 0, rq, bad, 0);
  endtask

  initial begin
    int nr;
    for (int k = 0; k < 64; k++) fa[k] = ((k >> 1) * 32'h1357_9BDF) & 32'hF0F0_F0EE;
    for (int i = 0; i < PAIRS; i++) begin
      img[i*32 +: 32] = 32'hC3A5_5A3C ^ (i * 32'h0001_0203);
      msk[i*32 +: 32] = (i % 3 == 0) ? 32'h0 : (32'hFFFF_00FF ^ i);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk({busy, cmd_valid, pwr_good, wr_open, done, timeout, rejected, locked, reload_go} == 0,
        "R12 reset state", {busy, cmd_valid, pwr_good, wr_open, done, timeout, rejected, locked, reload_go}, 0);

    // full burn, start poked mid-run must be ignored (R10)
    build(0);
    run(0, 1);
    cmp_array("R5 array after burn");
    chk(locked == 0, "R2 unlocked", locked, 0);

    // repeat: nothing new to burn, poll times out
    build(0);
    run(1, 0);
    cmp_array("R5 zero pairs skipped");

    // production plus key refused
    rq_prod = 1; rq_key = 1;
    exq.delete(); tq.delete();
    nr = n_rej;
    run(2, 0);
    chk(n_rej == nr + 1, "R1 rejected", n_rej - nr, 1);
    chk(out_cyc - st_cyc == 1, "R1 reject timing", out_cyc - st_cyc, 1);
    rq_prod = 0; rq_key = 0;

    // production lock set, general request refused
    fa[0] |= 32'h10; fa[1] |= 32'h10;
    build(1);
    nr = n_rej;
    run(2, 0);
    chk(n_rej == nr + 1, "R2 lock rejects", n_rej - nr, 1);
    chk(locked == 1, "R2 locked flag", locked, 1);

    // production lock set, reserved-only request proceeds
    rsvd = 1;
    for (int i = 0; i < PAIRS; i++) begin
      img[i*32 +: 32] = ~(32'hC3A5_5A3C ^ (i * 32'h0001_0203));
      msk[i*32 +: 32] = (i == 0) ? 32'h0 : 32'hFFFF_FFFF;
    end
    build(0);
    run(0, 0);
    cmp_array("R6 array after reserved burn");
    chk(locked == 1, "R2 locked kept", locked, 1);

    chk(r7_bad == 0, "R7 settle gap", r7_bad, 0);
    chk(pulse_bad == 0, "R10 pulse width", pulse_bad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    tests++; fails++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule